// File: doc/BRIEF.md
# Multi-Channel One-Shot Down-Counter Unit

This block provides a bank of independent one-shot timer channels. Each channel holds a count register and a run flag. The run flags of all channels sit together in one run register. Software arms a channel by writing 1 to its flag. In offset mode, a per-channel compare-match input can also arm it, provided that channel's link-enable bit is set.

While a channel's flag is 1, the channel decrements its count on every shared prescaled tick and drives its pulse output high. The flag drops by itself on the tick that decrements a count of zero. Writing 0 never clears a flag. The only ways to stop a channel are its own underflow and the synchronous clear input, which models power-on reset and entry to a low-power standby state.

The block is used as a pulse generator. Load a count N, then arm the channel, and the pulse output stays high for N+1 ticks. The run register, the link-enable register, the mode register and the count registers are all reached over a simple register bus. Writes use a one-cycle strobe. Reads are combinational.

Top module: `oneshot_unit`

## Requirements
- R1: After the asynchronous reset, the run register (address 0x0), the link-enable register (address 0x1) and the mode register (address 0x2) all read 0, and every pulse output is low.
- R2: A bus write to address 0x0 sets each run flag whose data bit (bit i for channel i) is 1. Data bits that are 0 leave their flags unchanged, so writing 0 never stops a running channel.
- R3: While a channel's run flag is 1, its count (read at address 0x8+i) decreases by exactly one on each cycle with tick high. In cycles without tick it holds its value.
- R4: A tick that arrives while a running channel's count is 0 is an underflow. In that same cycle the count wraps to 0xFFFF and the run flag clears.
- R5: Pulse output i equals run flag i at all times, so a channel loaded with N stays high for N+1 ticks.
- R6: When mode bit 0 is 1, link-enable bit i is 1 and compare-match input i is high in a cycle, run flag i is set. If either enable is 0, the match has no effect.
- R7: If a set (bus write or compare trigger) and an underflow hit the same flag in the same cycle, the flag ends up set.
- R8: One cycle with the synchronous clear input high returns the whole run register to 0.
- R9: A write to a channel's count register while that channel runs is ignored. While the channel is stopped, the same write loads the value.
- R10: The link-enable register (8 bits) and the mode register (bit 0) are plain read/write registers and return the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all run flags (standby entry) |
| tick | input | 1 | Shared prescaled count enable |
| match | input | 8 | Per-channel compare-match triggers |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| pulse | output | 8 | Per-channel one-shot pulse outputs |

## Verification
The assertions assume that tick, match, clr and the bus inputs are synchronous to clk and stable around its rising edge. They also assume that only one write strobe arrives per cycle. The bench keeps within these limits by changing every input on the falling edge and by holding each write strobe for exactly one cycle. Tick and match pulses are also one cycle wide, placed where each scenario needs them. The only overlap of events in the bench is the deliberate one in the same-cycle set/underflow case.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
   localparam int unsigned ADDR_RUN      = 0;
   localparam int unsigned ADDR_LINK     = 1;
   localparam int unsigned ADDR_MODE     = 2;
   localparam int unsigned ADDR_CNT_BASE = 8;

   typedef enum logic [1:0] {
      CH_IDLE_OP = 2'd0,
      CH_SET_OP  = 2'd1,
      CH_UF_OP   = 2'd2,
      CH_CLR_OP  = 2'd3
   } ch_op_e;
endpackage

// File: rtl/oneshot_chan.sv
module oneshot_chan #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic          set,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          run_o,
   output logic [CW-1:0] cnt_o
);
   import oneshot_pkg::*;

   logic          run_q;
   logic [CW-1:0] cnt_q;
   logic          at_zero;
   logic          uf;
   ch_op_e        op;

   assign at_zero = (cnt_q == '0);
   assign uf      = run_q & tick & at_zero;

   always_comb begin
      if (clr)      op = CH_CLR_OP;
      else if (set) op = CH_SET_OP;
      else if (uf)  op = CH_UF_OP;
      else          op = CH_IDLE_OP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else begin
         unique case (op)
            CH_CLR_OP:  run_q <= 1'b0;
            CH_SET_OP:  run_q <= 1'b1;
            CH_UF_OP:   run_q <= 1'b0;
            default:    run_q <= run_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load && !run_q) begin
         cnt_q <= load_val;
      end else if (run_q && tick) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign run_o = run_q;
   assign cnt_o = cnt_q;

   assert_uf_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick && cnt_q == '0) |=> (cnt_q == {CW{1'b1}}));

   assert_uf_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick && cnt_q == '0 && !set && !clr) |=> !run_q);

   assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(load && !run_q)) |=> $stable(cnt_q));

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !clr) |=> run_q);

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !run_q);

   assert_busy_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/oneshot_regs.sv
module oneshot_regs #(
   parameter int NCH = 8,
   parameter int CW  = 16,
   parameter int AW  = 4,
   parameter int DW  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_we,
   input  logic [AW-1:0]           bus_addr,
   input  logic [DW-1:0]           bus_wdata,
   output logic [DW-1:0]           bus_rdata,
   input  logic [NCH-1:0]          run,
   input  logic [NCH-1:0][CW-1:0]  cnt,
   output logic [NCH-1:0]          sw_set,
   output logic [NCH-1:0]          load,
   output logic [CW-1:0]           load_val,
   output logic [NCH-1:0]          link_en,
   output logic                    offset_mode
);
   import oneshot_pkg::*;

   localparam logic [AW-1:0] A_RUN  = AW'(ADDR_RUN);
   localparam logic [AW-1:0] A_LINK = AW'(ADDR_LINK);
   localparam logic [AW-1:0] A_MODE = AW'(ADDR_MODE);

   logic [NCH-1:0] link_q;
   logic           mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q <= '0;
         mode_q <= 1'b0;
      end else if (bus_we) begin
         if (bus_addr == A_LINK) link_q <= bus_wdata[NCH-1:0];
         if (bus_addr == A_MODE) mode_q <= bus_wdata[0];
      end
   end

   assign sw_set      = (bus_we && bus_addr == A_RUN) ? bus_wdata[NCH-1:0] : '0;
   assign load_val    = bus_wdata[CW-1:0];
   assign link_en     = link_q;
   assign offset_mode = mode_q;

   for (genvar i = 0; i < NCH; i++) begin : g_dec
      localparam logic [AW-1:0] A_CNT = AW'(ADDR_CNT_BASE + i);
      assign load[i] = bus_we && (bus_addr == A_CNT);
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_RUN)       bus_rdata = DW'(run);
      else if (bus_addr == A_LINK) bus_rdata = DW'(link_q);
      else if (bus_addr == A_MODE) bus_rdata = DW'(mode_q);
      else begin
         for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(ADDR_CNT_BASE + i)) bus_rdata = DW'(cnt[i]);
         end
      end
   end

   assert_link_rw_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_LINK) |=> (link_q == $past(bus_wdata[NCH-1:0])));

   assert_one_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load));
endmodule

// File: rtl/oneshot_unit.sv
module oneshot_unit #(
   parameter int NCH = 8,
   parameter int CW  = 16,
   parameter int AW  = 4,
   parameter int DW  = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           tick,
   input  logic [NCH-1:0] match,
   input  logic           bus_we,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   output logic [NCH-1:0] pulse
);
   import oneshot_pkg::*;

   initial begin
      assert (NCH >= 1 && NCH <= (2 ** AW) - ADDR_CNT_BASE)
         else $error("NCH does not fit the address map");
      assert (DW >= NCH && DW >= CW) else $error("DW too narrow");
   end

   logic [NCH-1:0]         run;
   logic [NCH-1:0][CW-1:0] cnt;
   logic [NCH-1:0]         sw_set;
   logic [NCH-1:0]         load;
   logic [CW-1:0]          load_val;
   logic [NCH-1:0]         link_en;
   logic                   offset_mode;
   logic [NCH-1:0]         hw_set;

   oneshot_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_we      (bus_we),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .run         (run),
      .cnt         (cnt),
      .sw_set      (sw_set),
      .load        (load),
      .load_val    (load_val),
      .link_en     (link_en),
      .offset_mode (offset_mode)
   );

   assign hw_set = offset_mode ? (match & link_en) : '0;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      oneshot_chan #(.CW(CW)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr),
         .tick     (tick),
         .set      (sw_set[i] | hw_set[i]),
         .load     (load[i]),
         .load_val (load_val),
         .run_o    (run[i]),
         .cnt_o    (cnt[i])
      );
   end

   assign pulse = run;

   assert_gated_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (offset_mode && (match & link_en) != '0 && !clr)
         |=> ((pulse & $past(match & link_en)) == $past(match & link_en)));

   assert_no_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!offset_mode && sw_set == '0) |=> ((pulse & ~$past(pulse)) == '0));

   assert_std_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pulse == '0));
endmodule

// File: tb/oneshot_unit_test.sv
module oneshot_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        tick = 1'b0;
   logic [7:0]  match = '0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  pulse;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   oneshot_unit uut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .match(match),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pulse(pulse)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(4'h0, v); chk("R1 run reg", v, 16'h0);
      rd(4'h1, v); chk("R1 link reg", v, 16'h0);
      rd(4'h2, v); chk("R1 mode reg", v, 16'h0);
      chk("R1 pulses", {8'h0, pulse}, 16'h0);
   endtask

   task automatic t_sw_start;
      logic [15:0] v;
      int width;
      wr(4'h8, 16'd3);
      wr(4'h0, 16'h0000);
      rd(4'h0, v); chk("R2 zero write idle", v, 16'h0);
      wr(4'h0, 16'h0001);
      rd(4'h0, v); chk("R2 set bit0", v, 16'h0001);
      chk("R5 pulse high", {8'h0, pulse}, 16'h0001);
      ticks(1);
      rd(4'h8, v); chk("R3 one tick", v, 16'd2);
      repeat (4) @(negedge clk);
      rd(4'h8, v); chk("R3 hold no tick", v, 16'd2);
      width = 1;
      for (int k = 0; k < 6 && pulse[0]; k++) begin
         ticks(1);
         if (pulse[0]) width++;
      end
      chk("R5 width N+1", 16'(width + 1), 16'd4);
      rd(4'h8, v); chk("R4 wrap", v, 16'hFFFF);
      rd(4'h0, v); chk("R4 flag cleared", v, 16'h0);
      chk("R5 pulse low", {8'h0, pulse}, 16'h0);
   endtask

   task automatic t_running;
      logic [15:0] v;
      wr(4'h9, 16'd5);
      wr(4'h0, 16'h0002);
      wr(4'h0, 16'h0000);
      rd(4'h0, v); chk("R2 zero write running", v, 16'h0002);
      wr(4'h9, 16'h0010);
      rd(4'h9, v); chk("R9 busy load ignored", v, 16'd5);
      ticks(6);
      rd(4'h0, v); chk("R4 ch1 stopped", v, 16'h0);
      wr(4'h9, 16'h0010);
      rd(4'h9, v); chk("R9 idle load", v, 16'h0010);
   endtask

   task automatic t_trigger;
      logic [15:0] v;
      wr(4'h1, 16'h0004);
      wr(4'h2, 16'h0001);
      rd(4'h1, v); chk("R10 link rw", v, 16'h0004);
      rd(4'h2, v); chk("R10 mode rw", v, 16'h0001);
      wr(4'hA, 16'd1);
      wr(4'hB, 16'd1);
      @(negedge clk); match = 8'h08;
      @(negedge clk); match = 8'h00;
      rd(4'h0, v); chk("R6 link off", v, 16'h0);
      @(negedge clk); match = 8'h04;
      @(negedge clk); match = 8'h00;
      rd(4'h0, v); chk("R6 triggered", v, 16'h0004);
      ticks(2);
      rd(4'h0, v); chk("R6 ch2 done", v, 16'h0);
      wr(4'h1, 16'h000C);
      wr(4'h2, 16'h0000);
      @(negedge clk); match = 8'h0C;
      @(negedge clk); match = 8'h00;
      rd(4'h0, v); chk("R6 mode off", v, 16'h0);
      chk("R6 pulses low", {8'h0, pulse}, 16'h0);
   endtask

   task automatic t_conflict;
      logic [15:0] v;
      wr(4'hC, 16'd0);
      wr(4'h0, 16'h0010);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 16'h0010; tick = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; tick = 1'b0;
      rd(4'h0, v); chk("R7 set wins", v, 16'h0010);
      rd(4'hC, v); chk("R7 count wrapped", v, 16'hFFFF);
   endtask

   task automatic t_standby;
      logic [15:0] v;
      wr(4'hD, 16'd100);
      wr(4'h0, 16'h0060);
      rd(4'h0, v); chk("R8 before clear", v, 16'h0070);
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      rd(4'h0, v); chk("R8 cleared", v, 16'h0);
      chk("R8 pulses low", {8'h0, pulse}, 16'h0);
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sw_start();
      t_running();
      t_trigger();
      t_conflict();
      t_standby();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule